// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block lets a host processor reach the 16-bit internal control registers of a serial PHY. The PHY exposes only a narrow port: one 16-bit data input, four strobes and an acknowledge. The host sees six 32-bit registers on a simple register bus. It places an address or a value in the staging register and then writes a one to bit 0 of a command register. The bridge raises the matching strobe, holds it until the PHY acknowledges, and clears the command bit when it is done. The host polls that bit to see when the operation has finished.

A PHY register write takes three host operations: capture the address, capture the value, then issue the write. A read takes two: capture the address, then issue the read. The PHY can return stale data on the first read after an address capture. For that reason one read command makes the bridge strobe the PHY twice, with one quiet cycle between the strobes, and it keeps only the second result. Every operation has a bounded length. If the PHY never acknowledges, the bridge gives up after a parameterized number of cycles and sets a sticky timeout flag. A command written while another one is in flight is dropped, and a sticky collision flag is set.

Top module: `phycr_bridge`

## Requirements
- R1: After reset, all six host registers read zero. The registers are staging data at byte offset 0x0C, result at 0x10, address capture at 0x14, value capture at 0x18, read at 0x1C and write at 0x20. Any other offset reads zero.
- R2: A write to 0x0C stores bits [15:0], which read back in [15:0]. Bits [31:16] of that register always read zero.
- R3: Writing a word with bit 0 set to 0x14 while idle raises `cr_cap_addr` on the next cycle. The strobe stays high until `cr_ack` is seen with it. `cr_data_in` carries the staging value that was present when the command was accepted. Bit 0 of 0x14 reads 1 while the operation runs and 0 once it ends.
- R4: Bit 0 written to 0x18 does the same for the value-capture strobe `cr_cap_data`.
- R5: Bit 0 written to 0x20 does the same for the PHY write strobe `cr_write`.
- R6: Bit 0 written to 0x1C produces two `cr_read` strobes, each held until acknowledged, with at least one low cycle between them. Only the data returned with the second acknowledge is loaded into bits [15:0] of 0x10.
- R7: At most one strobe is high in any cycle, and no strobe is high while the bridge is idle.
- R8: A command write (bit 0 set, to 0x14, 0x18, 0x1C or 0x20) made while an operation runs is ignored, and it sets the sticky collision flag at bit 17 of 0x10.
- R9: If an operation is still unfinished after TIMEOUT_CYC busy cycles (default 64), the strobes drop, the busy bit clears and the sticky timeout flag at bit 16 of 0x10 is set. No operation stays busy for longer than TIMEOUT_CYC cycles.
- R10: Writing 0x10 with bit 16 or bit 17 set clears that flag. A write to 0x10 never changes the stored result in bits [15:0].
- R11: Writing a command register with bit 0 clear has no effect. No strobe is raised and the busy bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Host register byte offset |
| bus_we | input | 1 | Host write enable for one cycle |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` (combinational) |
| cr_data_in | output | 16 | Address or value presented to the PHY |
| cr_cap_addr | output | 1 | PHY address capture strobe |
| cr_cap_data | output | 1 | PHY value capture strobe |
| cr_read | output | 1 | PHY read strobe |
| cr_write | output | 1 | PHY write strobe |
| cr_ack | input | 1 | PHY acknowledge for the strobe that is high |
| cr_data_out | input | 16 | PHY read data, valid with `cr_ack` during a read |

## Verification
The assertions assume the PHY raises `cr_ack` only while a strobe is high, holds it for a single cycle, and presents `cr_data_out` in the same cycle as the acknowledge of a read. The bench PHY model follows these rules. It acknowledges after a programmable delay, or never when it is set to be dead. It returns the inverse of the stored value on the first read after each address capture. Host writes last exactly one cycle and change only at the falling clock edge, so a command and its collision check always refer to a settled busy state.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

   typedef enum logic [1:0] {
      OP_CAPA = 2'd0,
      OP_CAPD = 2'd1,
      OP_RD   = 2'd2,
      OP_WR   = 2'd3
   } cr_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CAPA = 3'd1,
      ST_CAPD = 3'd2,
      ST_WR   = 3'd3,
      ST_RD1  = 3'd4,
      ST_GAP  = 3'd5,
      ST_RD2  = 3'd6
   } cr_state_e;

   localparam logic [7:0] OFS_STAGE  = 8'h0C;
   localparam logic [7:0] OFS_RESULT = 8'h10;
   localparam logic [7:0] OFS_CAPA   = 8'h14;
   localparam logic [7:0] OFS_CAPD   = 8'h18;
   localparam logic [7:0] OFS_RD     = 8'h1C;
   localparam logic [7:0] OFS_WR     = 8'h20;

endpackage

// File: rtl/phycr_hostregs.sv
module phycr_hostregs
   import phycr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CR_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  cr_op_e            cur_op,
   input  logic              rd_load,
   input  logic [CR_W-1:0]   rd_value,
   input  logic              abort,
   output logic              start,
   output cr_op_e            start_op,
   output logic [CR_W-1:0]   stage_q
);

   localparam int TO_BIT  = CR_W;
   localparam int ERR_BIT = CR_W + 1;

   logic            is_cmd;
   logic            cmd_hit;
   logic            w1c_hit;
   logic [CR_W-1:0] result_q;
   logic            to_flag;
   logic            err_flag;
   logic            unused_hi;

   assign unused_hi = ^bus_wdata[DATA_W-1:ERR_BIT+1];

   always_comb begin
      is_cmd   = 1'b1;
      start_op = OP_CAPA;
      case (bus_addr)
         ADDR_W'(OFS_CAPA): start_op = OP_CAPA;
         ADDR_W'(OFS_CAPD): start_op = OP_CAPD;
         ADDR_W'(OFS_RD):   start_op = OP_RD;
         ADDR_W'(OFS_WR):   start_op = OP_WR;
         default:           is_cmd   = 1'b0;
      endcase
   end

   assign cmd_hit = bus_we && is_cmd && bus_wdata[0];
   assign start   = cmd_hit && !busy;
   assign w1c_hit = bus_we && (bus_addr == ADDR_W'(OFS_RESULT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         result_q <= '0;
         to_flag  <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (bus_we && (bus_addr == ADDR_W'(OFS_STAGE)))
            stage_q <= bus_wdata[CR_W-1:0];
         if (rd_load)
            result_q <= rd_value;
         if (abort)
            to_flag <= 1'b1;
         else if (w1c_hit && bus_wdata[TO_BIT])
            to_flag <= 1'b0;
         if (cmd_hit && busy)
            err_flag <= 1'b1;
         else if (w1c_hit && bus_wdata[ERR_BIT])
            err_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_STAGE): bus_rdata[CR_W-1:0] = stage_q;
         ADDR_W'(OFS_RESULT): begin
            bus_rdata[CR_W-1:0] = result_q;
            bus_rdata[TO_BIT]   = to_flag;
            bus_rdata[ERR_BIT]  = err_flag;
         end
         ADDR_W'(OFS_CAPA): bus_rdata[0] = busy && (cur_op == OP_CAPA);
         ADDR_W'(OFS_CAPD): bus_rdata[0] = busy && (cur_op == OP_CAPD);
         ADDR_W'(OFS_RD):   bus_rdata[0] = busy && (cur_op == OP_RD);
         ADDR_W'(OFS_WR):   bus_rdata[0] = busy && (cur_op == OP_WR);
         default: ;
      endcase
   end

   // R8
   ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && busy) |=> (cur_op == $past(cur_op)));

   // R10
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(w1c_hit && bus_wdata[ERR_BIT])) |=> err_flag);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_load |=> $stable(result_q));

endmodule

// File: rtl/phycr_wdog.sv
module phycr_wdog #(
   parameter int TIMEOUT_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   output logic expire
);

   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

   logic [CNT_W-1:0] cnt_q;

   if (TIMEOUT_CYC < 4) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= '0;
      else if (busy)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expire = busy && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

   // R9
   window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < CNT_W'(TIMEOUT_CYC)));

endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
   import phycr_pkg::*;
#(
   parameter int CR_W          = 16,
   parameter bit DISCARD_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  cr_op_e          start_op,
   input  logic [CR_W-1:0] stage,
   input  logic            expire,
   input  logic            cr_ack,
   input  logic [CR_W-1:0] cr_data_out,
   output logic [CR_W-1:0] cr_data_in,
   output logic            cr_cap_addr,
   output logic            cr_cap_data,
   output logic            cr_read,
   output logic            cr_write,
   output logic            busy,
   output cr_op_e          cur_op,
   output logic            rd_load,
   output logic [CR_W-1:0] rd_value
);

   cr_state_e       state_q;
   cr_state_e       state_d;
   cr_state_e       rd_entry;
   logic [CR_W-1:0] latch_q;

   if (DISCARD_FIRST) begin : g_discard
      assign rd_entry = ST_RD1;
   end else begin : g_single
      assign rd_entry = ST_RD2;
   end

   always_comb begin
      state_d = state_q;
      if (state_q == ST_IDLE) begin
         if (start) begin
            case (start_op)
               OP_CAPA: state_d = ST_CAPA;
               OP_CAPD: state_d = ST_CAPD;
               OP_WR:   state_d = ST_WR;
               default: state_d = rd_entry;
            endcase
         end
      end else if (expire) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_CAPA, ST_CAPD, ST_WR, ST_RD2: if (cr_ack) state_d = ST_IDLE;
            ST_RD1: if (cr_ack) state_d = ST_GAP;
            ST_GAP: state_d = ST_RD2;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_op  <= OP_CAPA;
         latch_q <= '0;
      end else begin
         state_q <= state_d;
         if ((state_q == ST_IDLE) && start) begin
            cur_op  <= start_op;
            latch_q <= stage;
         end
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign cr_data_in  = latch_q;
   assign cr_cap_addr = (state_q == ST_CAPA);
   assign cr_cap_data = (state_q == ST_CAPD);
   assign cr_write    = (state_q == ST_WR);
   assign cr_read     = (state_q == ST_RD1) || (state_q == ST_RD2);
   assign rd_load     = (state_q == ST_RD2) && cr_ack && !expire;
   assign rd_value    = cr_data_out;

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cr_cap_addr, cr_cap_data, cr_read, cr_write}));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(cr_cap_addr || cr_cap_data || cr_read || cr_write));

   // R3
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_cap_addr && !cr_ack && !expire) |=> cr_cap_addr);

   // R6
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_read && cr_ack && !rd_load) |=> !cr_read);

endmodule

// File: rtl/phycr_bridge.sv
module phycr_bridge
   import phycr_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int CR_W          = 16,
   parameter int TIMEOUT_CYC   = 64,
   parameter bit DISCARD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CR_W-1:0]   cr_data_in,
   output logic              cr_cap_addr,
   output logic              cr_cap_data,
   output logic              cr_read,
   output logic              cr_write,
   input  logic              cr_ack,
   input  logic [CR_W-1:0]   cr_data_out
);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x20");
   end
   if (CR_W + 3 > DATA_W) begin : g_bad_width
      $error("DATA_W must hold CR_W plus two flag bits and a spare bit");
   end

   logic            start;
   cr_op_e          start_op;
   cr_op_e          cur_op;
   logic [CR_W-1:0] stage_q;
   logic            busy;
   logic            expire;
   logic            rd_load;
   logic [CR_W-1:0] rd_value;

   phycr_hostregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_W(CR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
      .cur_op(cur_op), .rd_load(rd_load), .rd_value(rd_value),
      .abort(expire), .start(start), .start_op(start_op), .stage_q(stage_q)
   );

   phycr_seq #(.CR_W(CR_W), .DISCARD_FIRST(DISCARD_FIRST)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
      .stage(stage_q), .expire(expire), .cr_ack(cr_ack),
      .cr_data_out(cr_data_out), .cr_data_in(cr_data_in),
      .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
      .cr_read(cr_read), .cr_write(cr_write), .busy(busy),
      .cur_op(cur_op), .rd_load(rd_load), .rd_value(rd_value)
   );

   phycr_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) wdog_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .expire(expire)
   );

   // R6
   load_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |-> (cr_read && cr_ack));

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !(cr_cap_addr || cr_cap_data || cr_read || cr_write));

endmodule

// File: tb/phycr_bridge_tb_top.sv
module phycr_bridge_tb_top;

   localparam int TO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [15:0] cr_data_in;
   logic        cr_cap_addr, cr_cap_data, cr_read, cr_write;
   logic        cr_ack = 1'b0;
   logic [15:0] cr_data_out = 16'h0;

   always #4 clk = ~clk;

   phycr_bridge #(.TIMEOUT_CYC(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cr_data_in(cr_data_in),
      .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
      .cr_read(cr_read), .cr_write(cr_write), .cr_ack(cr_ack),
      .cr_data_out(cr_data_out)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   bit cmp_on = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- PHY model ----------------
   logic [15:0] pmem [int];
   logic [15:0] p_addr = 16'h0, p_val = 16'h0;
   bit          p_stale = 1'b0;
   bit          phy_dead = 1'b0;
   int          phy_lat = 0;
   int          lat_cnt = 0;
   int          n_wr = 0, n_rd = 0, n_capa = 0, n_capd = 0;

   function automatic logic [15:0] mem_at(input logic [15:0] a);
      return pmem.exists(int'(a)) ? pmem[int'(a)] : 16'h0000;
   endfunction

   always @(negedge clk) begin
      if (cr_ack) begin
         cr_ack = 1'b0;
         lat_cnt = 0;
      end else if ((cr_cap_addr || cr_cap_data || cr_read || cr_write) && !phy_dead) begin
         if (lat_cnt >= phy_lat) begin
            cr_ack = 1'b1;
            lat_cnt = 0;
            if (cr_cap_addr) begin p_addr = cr_data_in; p_stale = 1'b1; n_capa++; end
            if (cr_cap_data) begin p_val = cr_data_in; n_capd++; end
            if (cr_write) begin pmem[int'(p_addr)] = p_val; n_wr++; end
            if (cr_read) begin
               cr_data_out = p_stale ? ~mem_at(p_addr) : mem_at(p_addr);
               p_stale = 1'b0;
               n_rd++;
            end
         end else begin
            lat_cnt++;
         end
      end else begin
         lat_cnt = 0;
      end
   end

   // ---------------- cycle reference model ----------------
   int          m_phase = 0, m_op = 0, m_cnt = 0, nph = 0;
   logic [15:0] m_stage = 0, m_latch = 0, m_result = 0;
   bit          m_to = 0, m_err = 0, was_busy = 0, cmd = 0, set_to = 0, set_err = 0;

   function automatic int op_of(input logic [7:0] a);
      case (a)
         8'h14: return 0;
         8'h18: return 1;
         8'h1C: return 2;
         8'h20: return 3;
         default: return -1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_op = 0; m_cnt = 0; m_stage = 0; m_latch = 0;
         m_result = 0; m_to = 0; m_err = 0;
      end else begin
         was_busy = (m_phase != 0);
         cmd = bus_we && (op_of(bus_addr) >= 0) && bus_wdata[0];
         set_to = 0;
         set_err = cmd && was_busy;
         nph = m_phase;
         if (was_busy) begin
            if (m_cnt == TO - 1) begin
               nph = 0;
               set_to = 1;
            end else begin
               case (m_phase)
                  1, 2, 3: if (cr_ack) nph = 0;
                  4: if (cr_ack) nph = 5;
                  5: nph = 6;
                  6: if (cr_ack) begin nph = 0; m_result = cr_data_out; end
                  default: nph = 0;
               endcase
            end
            m_cnt++;
         end else if (cmd) begin
            m_op = op_of(bus_addr);
            nph = (m_op == 0) ? 1 : (m_op == 1) ? 2 : (m_op == 2) ? 4 : 3;
            m_cnt = 0;
            m_latch = m_stage;
         end
         m_phase = nph;
         if (bus_we && bus_addr == 8'h10) begin
            if (bus_wdata[16]) m_to = 0;
            if (bus_wdata[17]) m_err = 0;
         end
         if (set_to) m_to = 1;
         if (set_err) m_err = 1;
         if (bus_we && bus_addr == 8'h0C) m_stage = bus_wdata[15:0];
      end
   end

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [31:0] r = 32'h0;
      if (a == 8'h0C) r[15:0] = m_stage;
      else if (a == 8'h10) r = {14'h0, m_err, m_to, m_result};
      else if (op_of(a) >= 0) r[0] = (m_phase != 0) && (m_op == op_of(a));
      return r;
   endfunction

   always @(negedge clk) begin
      #3;
      if (cmp_on && rst_n) begin
         // R7 strobes follow the model phase
         check("R7", "strobes", {28'h0, cr_cap_addr, cr_cap_data, cr_read, cr_write},
               {28'h0, m_phase == 1, m_phase == 2, (m_phase == 4 || m_phase == 6), m_phase == 3});
         // R3 data presented to the PHY
         check("R3", "cr_data_in", {16'h0, cr_data_in}, {16'h0, m_latch});
         // R1 host register view
         check("R1", "bus_rdata", bus_rdata, exp_rd(bus_addr));
      end
   end

   // ---------------- host tasks ----------------
   task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #3;
      d = bus_rdata;
   endtask

   task automatic wait_idle(input logic [7:0] a, output int n);
      n = 0;
      bus_addr = a;
      for (int i = 0; i < 500; i++) begin
         #3;
         if (bus_rdata[0] == 1'b0) break;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic phy_write(input logic [15:0] a, input logic [15:0] v);
      int n;
      host_wr(8'h0C, {16'h0, a}); host_wr(8'h14, 1); wait_idle(8'h14, n);
      host_wr(8'h0C, {16'h0, v}); host_wr(8'h18, 1); wait_idle(8'h18, n);
      host_wr(8'h20, 1); wait_idle(8'h20, n);
   endtask

   task automatic phy_read(input logic [15:0] a, output logic [15:0] v);
      int n;
      logic [31:0] r;
      host_wr(8'h0C, {16'h0, a}); host_wr(8'h14, 1); wait_idle(8'h14, n);
      host_wr(8'h1C, 1); wait_idle(8'h1C, n);
      host_rd(8'h10, r);
      v = r[15:0];
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] r;
      logic [15:0] v;
      int n, rd0, wr0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset values of all six registers
      foreach (op_of_list[i]) begin
         host_rd(op_of_list[i], r);
         check("R1", "reset value", r, 32'h0);
      end

      // R2 staging register keeps only 16 bits
      host_wr(8'h0C, 32'hFFFF_ABCD);
      host_rd(8'h0C, r);
      check("R2", "staging readback", r, 32'h0000_ABCD);

      // R3 busy bit visible while the PHY is slow
      phy_lat = 5;
      host_wr(8'h0C, 32'h1006);
      host_wr(8'h14, 1);
      host_rd(8'h14, r);
      check("R3", "capture busy bit", r, 32'h1);
      wait_idle(8'h14, n);
      host_rd(8'h14, r);
      check("R3", "capture done bit", r, 32'h0);
      check("R3", "PHY captured address", {16'h0, p_addr}, 32'h1006);

      // R4 R5 R6 write then read across lane-strided addresses and latencies
      for (int lane = 0; lane < 3; lane++) begin
         phy_lat = lane;
         phy_write(16'h1006 + 16'h100 * lane[15:0], 16'h3A00 + lane[15:0]);
         phy_write(16'h1002 + 16'h100 * lane[15:0], 16'h6E40 + lane[15:0]);
      end
      check("R4", "captured value", {16'h0, p_val}, 32'h6E42);
      check("R5", "PHY store", {16'h0, mem_at(16'h1202)}, 32'h6E42);
      for (int lane = 0; lane < 3; lane++) begin
         phy_lat = 3 - lane;
         rd0 = n_rd;
         phy_read(16'h1006 + 16'h100 * lane[15:0], v);
         check("R6", "second read result", {16'h0, v}, {16'h0, 16'h3A00 + lane[15:0]});
         check("R6", "two PHY reads", n_rd - rd0, 2);
         phy_read(16'h1002 + 16'h100 * lane[15:0], v);
         check("R6", "drive override read", {16'h0, v}, {16'h0, 16'h6E40 + lane[15:0]});
      end

      // R8 collision: write command during a slow capture is dropped
      phy_lat = 10;
      wr0 = n_wr;
      host_wr(8'h0C, 32'h0030);
      host_wr(8'h14, 1);
      host_wr(8'h20, 1);
      wait_idle(8'h14, n);
      repeat (4) @(negedge clk);
      check("R8", "no PHY write", n_wr - wr0, 0);
      host_rd(8'h10, r);
      check("R8", "collision flag", {31'h0, r[17]}, 32'h1);

      // R10 clearing the flag keeps the stored result
      host_wr(8'h10, 32'h0002_FFFF);
      host_rd(8'h10, r);
      check("R10", "flag cleared, result kept", r, {16'h0, 16'h6E42});

      // R11 command register written with bit 0 clear
      phy_lat = 0;
      wr0 = n_wr;
      host_wr(8'h20, 32'hFFFF_FFFE);
      host_rd(8'h20, r);
      check("R11", "no busy", r, 32'h0);
      check("R11", "no write strobe", n_wr - wr0, 0);

      // R9 dead PHY: bounded busy time and timeout flag
      phy_dead = 1'b1;
      host_wr(8'h1C, 1);
      wait_idle(8'h1C, n);
      check("R9", "busy cycles", n, TO);
      host_rd(8'h10, r);
      check("R9", "timeout flag", {31'h0, r[16]}, 32'h1);
      check("R9", "strobes low", {31'h0, cr_read}, 32'h0);
      phy_dead = 1'b0;
      host_wr(8'h10, 32'h0001_0000);
      host_rd(8'h10, r);
      check("R10", "timeout cleared", {31'h0, r[16]}, 32'h0);

      // R6 the bridge recovers after a timeout
      phy_read(16'h1106, v);
      check("R6", "read after timeout", {16'h0, v}, 32'h3A01);

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   logic [7:0] op_of_list [6] = '{8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};

endmodule